// File: doc/BRIEF.md
# Register Load/Store Instruction Executor

This block carries out one load/store instruction for a small scripted DMA engine. The instruction has two words. The first word gives the opcode, the addressing mode, the direction, a flag that suppresses the flush, the starting register and the byte count. The second word comes from a pointer-save register and holds either a full 32-bit memory address or a 24-bit signed offset. The block adds that offset to a data-structure base register.

Once `start` is pulsed, the block moves one to four bytes between an internal byte-addressed register file and external memory. It moves one byte per request/acknowledge handshake. After a store it asks the prefetch unit to flush, unless the instruction says not to. It ends each instruction with a single-cycle `done` pulse. That pulse carries `illegal` when the instruction was refused.

One register, the first-received-byte register, may serve as the source of a store. A load must never overwrite it.

Top module: `ldst_exec`

## Requirements
- R1: `start` is accepted only while `busy` is low. `busy` rises in the cycle after an accepted start and stays high until the cycle after the one-cycle `done` pulse. A `start` seen while busy is ignored.
- R2: An instruction whose first word has bits [31:29] other than 3'b111 transfers nothing. It ends with `done` and `illegal` both high in the cycle after the start.
- R3: With bit 28 of the first word clear, the first memory byte address equals the second word.
- R4: With bit 28 set, the first memory byte address equals the base register plus bits [23:0] of the second word, sign-extended to 32 bits.
- R5: Bit 24 set means load (memory to register) and clear means store (register to memory). Bits [22:16] give the first register address. Bytes move one per cycle in which `mem_req` and `mem_ack` are both high, with memory and register addresses each rising by one per byte.
- R6: Bits [2:0] give the byte count. The legal counts are 1 to 4. The sum of the low two address bits and the count must not exceed 4. A count of 0, a count above 4, or a range that crosses a 4-byte boundary transfers nothing and raises `illegal` with `done`.
- R7: A store with bit 25 clear gives exactly one `flush_req` pulse, in the cycle after the last byte is acknowledged. `done` follows in the next cycle. A store with bit 25 set, and any load, gives no flush.
- R8: Bits [27:26], bit 23 and bits [15:3] of the first word have no effect on the transfer.
- R9: A load never writes the protected register (address parameter `PROT_REG`, default 7'h08). The other bytes of the same load are still written.
- R10: While `mem_req` is high without `mem_ack`, the request, its address and its direction hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the instruction presented on the word inputs |
| instr_word | input | 32 | First instruction word |
| psave_word | input | 32 | Second word, taken from the pointer-save register |
| base_reg | input | 32 | Data-structure base address |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Instruction refused; valid with `done` |
| flush_req | output | 1 | One-cycle prefetch flush request |
| reg_addr | output | 7 | Register file byte address |
| reg_rdata | input | 8 | Register file read data |
| reg_wr | output | 1 | Register file write strobe |
| reg_wdata | output | 8 | Register file write data |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge for the current byte |

## Verification
The bench runs a range that ends exactly on a 4-byte boundary and one that crosses it by a byte. A design that measures the span off by one would either refuse the first or let the second move bytes. A negative relative offset checks the sign extension: an adder that zero-extends would land 16 MB away. A load spanning the protected register shows whether that byte is wrongly overwritten or whether its neighbours are wrongly skipped. A second start while a transfer is running shows whether that start is wrongly latched and replays a second instruction. Store flush, store without flush and load each count the `flush_req` pulses, and reserved bits set to ones must leave the transfer unchanged.

// File: rtl/ldst_exec.sv
module ldst_exec #(
  parameter int ADDR_W    = 32,
  parameter int REG_AW    = 7,
  parameter int OFF_W     = 24,
  parameter int MAX_BYTES = 4,
  parameter int PROT_REG  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       instr_word,
  input  logic [ADDR_W-1:0] psave_word,
  input  logic [ADDR_W-1:0] base_reg,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic              flush_req,
  output logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_rdata,
  output logic              reg_wr,
  output logic [7:0]        reg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  input  logic              mem_ack
);

  localparam int LW = $clog2(MAX_BYTES);
  localparam int SW = LW + 2;
  localparam logic [SW-1:0] MAXB = SW'(MAX_BYTES);
  localparam logic [REG_AW-1:0] PROT = REG_AW'(PROT_REG);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FLUSH, S_DONE} st_t;
  st_t st;

  logic [2:0]        op_kind;
  logic              rel, no_fl, is_load_d;
  logic [REG_AW-1:0] rsel;
  logic [2:0]        cnt;
  logic [ADDR_W-1:0] ea;
  logic [SW-1:0]     span;
  logic              bad;

  assign op_kind   = instr_word[31:29];
  assign rel       = instr_word[28];
  assign no_fl     = instr_word[25];
  assign is_load_d = instr_word[24];
  assign rsel      = instr_word[16 +: REG_AW];
  assign cnt       = instr_word[2:0];

  assign ea   = rel ? base_reg + {{(ADDR_W-OFF_W){psave_word[OFF_W-1]}}, psave_word[OFF_W-1:0]}
                    : psave_word;
  assign span = SW'(ea[LW-1:0]) + SW'(cnt);
  assign bad  = (op_kind != 3'b111) || (cnt == 3'd0) || (SW'(cnt) > MAXB) || (span > MAXB);

  logic [ADDR_W-1:0] cur_addr;
  logic [REG_AW-1:0] cur_reg;
  logic [2:0]        left;
  logic              ld_q, fl_q, ill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      cur_reg  <= '0;
      left     <= '0;
      ld_q     <= 1'b0;
      fl_q     <= 1'b0;
      ill_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          ill_q    <= bad;
          cur_addr <= ea;
          cur_reg  <= rsel;
          left     <= cnt;
          ld_q     <= is_load_d;
          fl_q     <= ~is_load_d & ~no_fl;
          st       <= bad ? S_DONE : S_XFER;
        end
        S_XFER: if (mem_ack) begin
          cur_addr <= cur_addr + 1'b1;
          cur_reg  <= cur_reg + 1'b1;
          left     <= left - 1'b1;
          if (left == 3'd1) st <= fl_q ? S_FLUSH : S_DONE;
        end
        S_FLUSH: st <= S_DONE;
        default: begin
          st    <= S_IDLE;
          ill_q <= 1'b0;
        end
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_DONE);
  assign illegal   = done & ill_q;
  assign flush_req = (st == S_FLUSH);
  assign mem_req   = (st == S_XFER);
  assign mem_we    = mem_req & ~ld_q;
  assign mem_addr  = cur_addr;
  assign mem_wdata = reg_rdata;
  assign reg_addr  = cur_reg;
  assign reg_wr    = mem_req & mem_ack & ld_q & (cur_reg != PROT);
  assign reg_wdata = mem_rdata;

endmodule

// File: rtl/ldst_exec_chk.sv
module ldst_exec_chk #(
  parameter int ADDR_W   = 32,
  parameter int REG_AW   = 7,
  parameter int PROT_REG = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              illegal,
  input logic              flush_req,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  localparam logic [REG_AW-1:0] PROT = REG_AW'(PROT_REG);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R1
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R1
  AST_ILLEGAL_NO_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (done && !mem_req)); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (!mem_req || mem_addr == $past(mem_addr) + 1'b1)); // R5
  AST_FLUSH_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> done); // R7
  AST_FLUSH_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !mem_req); // R7
  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr != PROT)); // R9
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
endmodule

bind ldst_exec ldst_exec_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW), .PROT_REG(PROT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .illegal(illegal),
  .flush_req(flush_req), .reg_addr(reg_addr), .reg_wr(reg_wr), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/ldst_exec_tb_top.sv
module ldst_exec_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [31:0] instr_word = '0, psave_word = '0, base_reg = '0;
  logic        busy, done, illegal, flush_req, reg_wr, mem_req, mem_we;
  logic [6:0]  reg_addr;
  logic [7:0]  reg_rdata, reg_wdata, mem_wdata, mem_rdata;
  logic [31:0] mem_addr;
  logic        mem_ack;

  ldst_exec dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_word(instr_word),
    .psave_word(psave_word), .base_reg(base_reg), .busy(busy), .done(done),
    .illegal(illegal), .flush_req(flush_req), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  function automatic logic [7:0] mpat(input logic [7:0] a);
    return a * 8'd7 + 8'd3;
  endfunction
  function automatic logic [7:0] rpat(input logic [6:0] r);
    return {1'b0, r} ^ 8'hC3;
  endfunction

  logic [7:0]  mem [256];
  logic [7:0]  rf  [128];
  logic [31:0] hist_addr [64];
  logic [6:0]  hist_reg  [64];
  int          hs_total, fl_total;

  assign reg_rdata = rf[reg_addr];
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(negedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else        mem_ack <= mem_req && !mem_ack;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= mpat(8'(i));
      for (int i = 0; i < 128; i++) rf[i]  <= rpat(7'(i));
      hs_total <= 0;
      fl_total <= 0;
    end else begin
      if (mem_req && mem_ack) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        hist_addr[hs_total[5:0]] <= mem_addr;
        hist_reg[hs_total[5:0]]  <= reg_addr;
        hs_total <= hs_total + 1;
      end
      if (reg_wr) rf[reg_addr] <= reg_wdata;
      if (flush_req) fl_total <= fl_total + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  int hs0, fl0, ill_seen, wait_cyc;

  task automatic launch(input logic [31:0] iw, input logic [31:0] pw, input logic [31:0] bw);
    hs0 = hs_total;
    fl0 = fl_total;
    @(negedge clk);
    instr_word = iw; psave_word = pw; base_reg = bw; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    wait_cyc = 0;
    while (!done && wait_cyc < 60) begin
      @(negedge clk);
      wait_cyc++;
    end
    chk(done, req, "done pulse seen", done, 1);
    ill_seen = illegal;
    @(negedge clk);
    chk(!busy && !done, "R1", "idle after done", {busy, done}, 0);
  endtask

  // instr, pointer-save word, base, expected first address, illegal, flush
  localparam logic [129:0] VEC [10] = '{
    {32'hE1200004, 32'h00000010, 32'h0,        32'h00000010, 1'b0, 1'b0},
    {32'hE0300003, 32'h00000021, 32'h0,        32'h00000021, 1'b0, 1'b1},
    {32'hE2400002, 32'h00000040, 32'h0,        32'h00000040, 1'b0, 1'b0},
    {32'hF1100002, 32'h00FFFFF0, 32'h00000100, 32'h000000F0, 1'b0, 1'b0},
    {32'hFCD0FFFC, 32'h00000008, 32'h00000050, 32'h00000058, 1'b0, 1'b1},
    {32'hC1200004, 32'h00000010, 32'h0,        32'h0,        1'b1, 1'b0},
    {32'hE1200000, 32'h00000010, 32'h0,        32'h0,        1'b1, 1'b0},
    {32'hE1200005, 32'h00000010, 32'h0,        32'h0,        1'b1, 1'b0},
    {32'hE1200002, 32'h00000013, 32'h0,        32'h0,        1'b1, 1'b0},
    {32'hE1200002, 32'h00000012, 32'h0,        32'h00000012, 1'b0, 1'b0}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !illegal && !flush_req && !mem_req && !reg_wr,
        "R1", "reset outputs quiet",
        {busy, done, illegal, flush_req, mem_req, reg_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R7 R8: table walk
    for (int v = 0; v < 10; v++) begin
      logic [31:0] iw, ea;
      logic        e_ill, e_fl, is_ld;
      int          n, nhs;
      logic [6:0]  r0;
      iw    = VEC[v][129:98];
      ea    = VEC[v][33:2];
      e_ill = VEC[v][1];
      e_fl  = VEC[v][0];
      is_ld = iw[24];
      r0    = iw[22:16];
      n     = e_ill ? 0 : int'(iw[2:0]);
      launch(iw, VEC[v][97:66], VEC[v][65:34]);
      wait_done("R1");
      nhs = hs_total - hs0;
      chk(ill_seen == e_ill, e_ill ? "R6" : "R2", $sformatf("vec %0d illegal", v), ill_seen, e_ill);
      chk(nhs == n, "R6", $sformatf("vec %0d byte count", v), nhs, n);
      chk((fl_total - fl0) == int'(e_fl), "R7", $sformatf("vec %0d flush pulses", v),
          fl_total - fl0, e_fl);
      for (int k = 0; k < n; k++) begin
        logic [31:0] a;
        logic [6:0]  r;
        a = ea + 32'(k);
        r = r0 + 7'(k);
        chk(hist_addr[6'(hs0 + k)] == a, iw[28] ? "R4" : "R3",
            $sformatf("vec %0d byte %0d mem addr", v, k), hist_addr[6'(hs0 + k)], a);
        chk(hist_reg[6'(hs0 + k)] == r, "R5",
            $sformatf("vec %0d byte %0d reg addr", v, k), hist_reg[6'(hs0 + k)], r);
        if (is_ld)
          chk(rf[r] == mpat(a[7:0]), "R5", $sformatf("vec %0d load data", v), rf[r], mpat(a[7:0]));
        else
          chk(mem[a[7:0]] == rpat(r), v == 4 ? "R8" : "R5",
              $sformatf("vec %0d store data", v), mem[a[7:0]], rpat(r));
      end
    end

    // R9: load across the protected register 0x08 (regs 6..9 from memory 0x60..0x63)
    launch(32'hE1060004, 32'h00000060, 32'h0);
    wait_done("R9");
    chk(rf[8] == rpat(7'd8), "R9", "protected register kept", rf[8], rpat(7'd8));
    chk(rf[6] == mpat(8'h60) && rf[7] == mpat(8'h61), "R9", "bytes below written",
        {rf[6], rf[7]}, {mpat(8'h60), mpat(8'h61)});
    chk(rf[9] == mpat(8'h63), "R9", "byte above written", rf[9], mpat(8'h63));
    chk(hs_total - hs0 == 4, "R9", "all four handshakes", hs_total - hs0, 4);

    // R1: second start while busy is ignored
    launch(32'hE1700002, 32'h00000070, 32'h0);
    @(negedge clk);
    instr_word = 32'hC0000001; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R1");
    chk(ill_seen == 0, "R1", "busy start not latched", ill_seen, 0);
    chk(hs_total - hs0 == 2, "R1", "only first instruction moved bytes", hs_total - hs0, 2);
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "no replayed instruction", busy, 0);

    // R10: request held while unacknowledged
    launch(32'hE0300001, 32'h00000080, 32'h0);
    chk(mem_req && !mem_ack && mem_we && mem_addr == 32'h80, "R10", "request raised",
        {mem_req, mem_ack, mem_we}, 3'b101);
    wait_done("R10");
    chk(hs_total - hs0 == 1 && fl_total - fl0 == 1, "R10", "single byte store completed",
        hs_total - hs0, 1);

    finish_run();
  end
endmodule